// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

A small cache of page translations placed in front of the physical address path. A virtual address is split into a page offset and a virtual page number (VPN). The low bits of the VPN select one set, and the remaining upper bits form a tag that is compared against every way of that set at once. On a match with a valid entry, the stored physical page number (PPN) is joined to the untouched page offset to form the physical address. The block also returns the two permission bits of the entry and flags a fault when the request's access kind is not allowed.

Translations are loaded through a fill port after a miss has been resolved elsewhere. Within a set, the fill takes a free way if there is one, otherwise the least recently used way. A single-cycle global invalidate empties the whole buffer. The default parameters give 14-bit virtual and 12-bit physical addresses, 64-byte pages, 4 sets and 4 ways. Setting 32-bit addresses, 12 offset bits and 16 sets gives the larger data-side configuration.

Top module: `tlb_sa`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` and `rsp_hit` are low, and the first lookup misses.
- R2: The page offset is `va[5:0]` and the VPN is `va[13:6]`. The set index is VPN[1:0] and the tag is VPN[7:2]. A hit needs a valid entry with a matching tag in the indexed set, so entries in other sets are never affected.
- R3: A lookup sampled with `lk_valid` high gives `rsp_valid` high for exactly the next cycle. With no request, `rsp_valid` is low.
- R4: On a hit, `rsp_pa` is {PPN, offset}. The offset bits `rsp_pa[5:0]` always equal the offset of the request.
- R5: On a miss, `rsp_hit`, `rsp_rw`, `rsp_us` and `rsp_fault` are 0, and the page bits of `rsp_pa` are 0.
- R6: On a hit, `rsp_rw` (1 = writable) and `rsp_us` (1 = user accessible) show the entry's bits. `rsp_fault` is 1 exactly when (`lk_write` and not rw) or (`lk_user` and not us).
- R7: A fill writes into the lowest-numbered invalid way of the set indexed by `fill_vpn`. If the set has no invalid way, it writes into the least recently used way.
- R8: A lookup hit makes the matched way most recently used, and so does a fill for the way it writes. A fill takes precedence over a lookup hit in the same cycle when recency is updated.
- R9: `inv_all` clears every valid bit in one cycle. A fill in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | Request is a write |
| lk_user | input | 1 | Request comes from user mode |
| fill_en | input | 1 | Insert a translation |
| fill_vpn | input | VA_W-OFF_W | VPN of the inserted translation |
| fill_ppn | input | PA_W-OFF_W | PPN of the inserted translation |
| fill_rw | input | 1 | Writable permission of the inserted entry |
| fill_us | input | 1 | User permission of the inserted entry |
| inv_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_rw | output | 1 | Writable bit of the hit entry |
| rsp_us | output | 1 | User bit of the hit entry |
| rsp_fault | output | 1 | Permission violation on a hit |

## Verification
The hardest state to reach from the ports is a full set whose recency order is known exactly. Only then does a fill have a single predictable victim. The stimulus first fills one set completely, then touches its ways through lookups in a chosen order. It then checks which translation disappears after each of two further fills, with an extra hit between them that reorders recency. Global invalidate is tested both alone and together with a fill in the same cycle.

// File: rtl/tlb_sa.sv
module tlb_sa #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_va,
  input  logic                  lk_write,
  input  logic                  lk_user,
  input  logic                  fill_en,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic                  fill_rw,
  input  logic                  fill_us,
  input  logic                  inv_all,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [PA_W-1:0]       rsp_pa,
  output logic                  rsp_rw,
  output logic                  rsp_us,
  output logic                  rsp_fault
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  vld   [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [WAYS-1:0]  rw_q  [SETS];
  logic [WAYS-1:0]  us_q  [SETS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  wire [IDX_W-1:0] l_idx = lk_va[OFF_W +: IDX_W];
  wire [TAG_W-1:0] l_tag = lk_va[OFF_W+IDX_W +: TAG_W];
  wire [IDX_W-1:0] f_idx = fill_vpn[IDX_W-1:0];
  wire [TAG_W-1:0] f_tag = fill_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0]  hitv;
  logic [WAY_W-1:0] h_way, victim, t_way;
  logic [IDX_W-1:0] t_set;
  logic             t_en;

  always_comb begin
    h_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitv[w] = vld[l_idx][w] && (tag_q[l_idx][w] == l_tag);
      if (hitv[w]) h_way = WAY_W'(w);
    end
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[f_idx][w] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
    for (int w = WAYS-1; w >= 0; w--)
      if (!vld[f_idx][w]) victim = WAY_W'(w);
    t_en  = 1'b0;
    t_set = l_idx;
    t_way = h_way;
    if (fill_en && !inv_all) begin
      t_en  = 1'b1;
      t_set = f_idx;
      t_way = victim;
    end else if (lk_valid && |hitv) begin
      t_en = 1'b1;
    end
  end

  wire             any_hit = |hitv;
  wire [PPN_W-1:0] h_ppn   = any_hit ? ppn_q[l_idx][h_way] : '0;
  wire             h_rw    = any_hit & rw_q[l_idx][h_way];
  wire             h_us    = any_hit & us_q[l_idx][h_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        rw_q[s] <= '0;
        us_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          ppn_q[s][w] <= '0;
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      if (inv_all) begin
        for (int s = 0; s < SETS; s++) vld[s] <= '0;
      end else if (fill_en) begin
        vld[f_idx][victim]   <= 1'b1;
        tag_q[f_idx][victim] <= f_tag;
        ppn_q[f_idx][victim] <= fill_ppn;
        rw_q[f_idx][victim]  <= fill_rw;
        us_q[f_idx][victim]  <= fill_us;
      end
      if (t_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == t_way) age_q[t_set][w] <= '0;
          else if (age_q[t_set][w] < age_q[t_set][t_way])
            age_q[t_set][w] <= age_q[t_set][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_rw    <= 1'b0;
      rsp_us    <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit   <= any_hit;
        rsp_pa    <= {h_ppn, lk_va[OFF_W-1:0]};
        rsp_rw    <= h_rw;
        rsp_us    <= h_us;
        rsp_fault <= any_hit & ((lk_write & ~h_rw) | (lk_user & ~h_us));
      end
    end
  end

  a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0])));
  a_r5_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa[PA_W-1:OFF_W] == '0 && !rsp_rw && !rsp_us && !rsp_fault));
  a_r6_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv));

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    logic [WAYS-1:0] oldest;
    for (genvar w = 0; w < WAYS; w++) begin : g_w
      assign oldest[w] = (age_q[s][w] == WAY_W'(WAYS-1));
    end
    a_r8_one_lru_way: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1);
    a_r9_inv_empties: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (vld[s] == '0));
  end
endmodule

// File: tb/sim_tlb_sa.sv
module sim_tlb_sa;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [13:0] lk_va = '0;
  logic        fill_en = 1'b0, fill_rw = 1'b0, fill_us = 1'b0, inv_all = 1'b0;
  logic [7:0]  fill_vpn = '0;
  logic [5:0]  fill_ppn = '0;
  logic        rsp_valid, rsp_hit, rsp_rw, rsp_us, rsp_fault;
  logic [11:0] rsp_pa;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlb_sa u0 (.clk, .rst_n, .lk_valid, .lk_va, .lk_write, .lk_user,
    .fill_en, .fill_vpn, .fill_ppn, .fill_rw, .fill_us, .inv_all,
    .rsp_valid, .rsp_hit, .rsp_pa, .rsp_rw, .rsp_us, .rsp_fault);

  // {va, write, user, exp_hit, exp_pa, exp_fault}
  localparam logic [29:0] VEC [8] = '{
    {14'h03D4, 1'b0, 1'b1, 1'b1, 12'h354, 1'b0},
    {14'h0B8F, 1'b0, 1'b1, 1'b0, 12'h00F, 1'b0},
    {14'h017F, 1'b1, 1'b1, 1'b1, 12'hABF, 1'b1},
    {14'h0241, 1'b0, 1'b1, 1'b1, 12'h441, 1'b1},
    {14'h0241, 1'b1, 1'b0, 1'b1, 12'h441, 1'b0},
    {14'h0340, 1'b1, 1'b1, 1'b1, 12'hCC0, 1'b0},
    {14'h0040, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0},
    {14'h056A, 1'b0, 1'b1, 1'b0, 12'h02A, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [13:0] va, input logic wr, input logic usr);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_write = wr; lk_user = usr;
    @(posedge clk); #1;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [7:0] vpn, input logic [5:0] ppn,
                      input logic rw, input logic us, input logic inv);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rw = rw; fill_us = us; inv_all = inv;
    @(negedge clk);
    fill_en = 1'b0; inv_all = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 rsp_valid in reset", 32'(rsp_valid), 0);
    check("R1 rsp_hit in reset", 32'(rsp_hit), 0);
    @(negedge clk); rst_n = 1'b1;
    lookup(14'h03D4, 1'b0, 1'b0);
    check("R1 first lookup misses", 32'(rsp_hit), 0);
    check("R3 rsp_valid after request", 32'(rsp_valid), 1);
    @(posedge clk); #1;
    check("R3 rsp_valid idle", 32'(rsp_valid), 0);

    fill(8'h0F, 6'h0D, 1'b1, 1'b1, 1'b0);
    fill(8'h05, 6'h2A, 1'b0, 1'b1, 1'b0);
    fill(8'h09, 6'h11, 1'b1, 1'b0, 1'b0);
    fill(8'h0D, 6'h33, 1'b1, 1'b1, 1'b0);

    foreach (VEC[i]) begin
      lookup(VEC[i][29:16], VEC[i][15], VEC[i][14]);
      check($sformatf("R2 vec%0d hit", i), 32'(rsp_hit), 32'(VEC[i][13]));
      check($sformatf("R4 R5 vec%0d pa", i), 32'(rsp_pa), 32'(VEC[i][12:1]));
      check($sformatf("R6 vec%0d fault", i), 32'(rsp_fault), 32'(VEC[i][0]));
    end

    // R7: set 1 has one free way left
    fill(8'h11, 6'h07, 1'b1, 1'b1, 1'b0);
    lookup(14'h0140, 1'b0, 1'b0);
    lookup(14'h0240, 1'b0, 1'b0);
    lookup(14'h0440, 1'b0, 1'b0);
    check("R7 fill into free way", 32'(rsp_pa), 32'h1C0);
    lookup(14'h0340, 1'b0, 1'b0);
    // R8: recency now D,11,9,5 -> 5 is evicted
    fill(8'h19, 6'h3C, 1'b1, 1'b1, 1'b0);
    lookup(14'h0140, 1'b0, 1'b0);
    check("R8 LRU way evicted", 32'(rsp_hit), 0);
    lookup(14'h0240, 1'b0, 1'b0);
    check("R8 recent way kept", 32'(rsp_hit), 1);
    check("R6 rw bit", 32'(rsp_rw), 1);
    check("R6 us bit", 32'(rsp_us), 0);
    lookup(14'h0640, 1'b0, 1'b0);
    check("R7 filled over LRU", 32'(rsp_pa), 32'hF00);
    // recency 19,9,D,11 -> 11 evicted
    fill(8'h1D, 6'h15, 1'b1, 1'b1, 1'b0);
    lookup(14'h0440, 1'b0, 1'b0);
    check("R8 hit reorders recency", 32'(rsp_hit), 0);
    lookup(14'h0340, 1'b0, 1'b0);
    check("R8 touched way kept", 32'(rsp_hit), 1);
    lookup(14'h0740, 1'b0, 1'b0);
    check("R7 second replacement", 32'(rsp_pa), 32'h540);
    lookup(14'h03C0, 1'b0, 1'b0);
    check("R2 other set untouched", 32'(rsp_pa), 32'h340);

    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    lookup(14'h03C0, 1'b0, 1'b0);
    check("R9 set 3 cleared", 32'(rsp_hit), 0);
    lookup(14'h0340, 1'b0, 1'b0);
    check("R9 set 1 cleared", 32'(rsp_hit), 0);
    fill(8'h0F, 6'h0D, 1'b1, 1'b1, 1'b1);
    lookup(14'h03C0, 1'b0, 1'b0);
    check("R9 fill dropped under invalidate", 32'(rsp_hit), 0);
    fill(8'h0F, 6'h22, 1'b1, 1'b1, 1'b0);
    lookup(14'h03C5, 1'b0, 1'b0);
    check("R7 refill after invalidate", 32'(rsp_pa), 32'h885);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule